// File: doc/BRIEF.md
# Secondary Cache Address Sequencer

This block drives the low-order address lines and the control strobes of an external second-level cache while the processor moves a cache line. It accepts an access (read or write, four-beat burst or single beat) from the host side and runs it on a fixed clock schedule. The schedule is the same for plain asynchronous SRAMs and for pipelined burst SRAMs. With plain SRAMs it walks cache address bits [4:3] through the interleaved burst order. With burst SRAMs it presents the start address once, pulses an address strobe, and then pulses an advance signal for each further beat. The low address bits leave the block on two identical copies so that each copy loads only half of the SRAM array.

Per-byte control comes out in one of two encodings, chosen by a mode input. In one encoding the byte lanes act as write enables. In the other they act as byte selects, with two separate read/write lines beside them. Output enable is raised only while the SRAMs drive data back toward the host. When a replaced sector holds modified lines, a writeback walk steps cache address bits [6:5] through each flagged line in turn and signals completion.

Top module: `l2_seq_top`

## Requirements
- R1: While reset is held, and in the first idle cycle after it, `c_strobe`, `c_adv`, `c_oe`, `c_byte`, `c_rw`, `rdy`, `busy` and `wb_done` are all 0.
- R2: `ca_lo_a` and `ca_lo_b` carry the same value in every cycle.
- R3: With `strap_burst_sram`=0, the low address in beat k (k=0..3) equals req_addr[1:0] XOR k, where req_addr[1:0] is the value at acceptance. When idle with no writeback, the low address follows req_addr[1:0] directly.
- R4: With `strap_burst_sram`=1, the low address holds the start value for the whole access. `c_strobe` is high only in the first clock of beat 0, and `c_adv` is high only in the first clock of each of beats 1 to 3. With the strap at 0, both stay low.
- R5: `ca_hi` follows req_addr[3:2] while idle, and holds the value captured at acceptance for the whole access.
- R6: An access starts in the cycle after the one in which `req_valid` is sampled. Beat 0 lasts 3 clocks for a read and 4 clocks for a write. Each later beat lasts 2 clocks. A burst (`req_burst`=1) has 4 beats and a single access has 1. `rdy` is high on the last clock of every beat. This schedule applies in both SRAM modes.
- R7: A writeback started with a mask on `wb_dirty` visits only the set bits, in ascending order. Each line lasts 4 clocks, with `ca_hi` equal to the line index, `c_oe`=1 and the low address 0. `wb_done` pulses in the cycle after the last line. An empty mask gives `wb_done` in the cycle after `wb_start`.
- R8: With `byte_mode`=1 (write enables), `c_byte` equals the accepted byte enables during write accesses and is 0 during reads. `c_rw` stays 00.
- R9: With `byte_mode`=0 (byte selects), `c_byte` equals the accepted byte enables during every access. `c_rw` is 11 during writes and 00 during reads. Outside an access both are 0.
- R10: `c_oe` is 1 in exactly the cycles of read accesses and writeback lines, and never during a write access.
- R11: `req_valid` and `wb_start` are ignored while `busy` is 1. If both are raised in the same idle cycle, the access is taken and the writeback is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, sampled when idle |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single beat |
| req_addr | input | 4 | Host address bits [6:3]; [3:2] select the line, [1:0] the start quadword |
| req_be | input | 8 | Host byte enables |
| strap_burst_sram | input | 1 | 1 = pipelined burst SRAMs, 0 = plain asynchronous SRAMs |
| byte_mode | input | 1 | 1 = write-enable encoding, 0 = byte-select encoding |
| wb_start | input | 1 | Starts a sector writeback walk |
| wb_dirty | input | 4 | One bit per line of the sector, set for a modified line |
| ca_lo_a | output | 2 | Cache address bits [4:3], copy A |
| ca_lo_b | output | 2 | Cache address bits [4:3], copy B |
| ca_hi | output | 2 | Cache address bits [6:5] |
| c_strobe | output | 1 | Burst SRAM address strobe |
| c_adv | output | 1 | Burst SRAM advance |
| c_oe | output | 1 | SRAM output enable |
| c_byte | output | 8 | Byte write enables or byte selects |
| c_rw | output | 2 | Read/write lines in byte-select encoding |
| rdy | output | 1 | Last clock of a beat |
| busy | output | 1 | Access or writeback in progress |
| wb_done | output | 1 | One-cycle pulse at the end of a writeback walk |

## Verification
Bursts that start at quadwords 0, 1, 2 and 3 make the interleaved XOR order differ from a linear count, so a sequencer that merely increments would be exposed. Reads and writes of both lengths tell the 3-clock and 4-clock first beats apart from the 2-clock later beats, and the same accesses repeated with the strap set show that the address holds while the strobe and advance pulses appear. The same access in each byte encoding separates write-enable from byte-select behaviour. Writebacks with empty, single-bit, sparse and full masks check skipping and ordering, and requests raised mid-access check that nothing restarts.

// File: rtl/l2_seq_pkg.sv
package l2_seq_pkg;

  typedef enum logic {
    BYTE_SEL = 1'b0,
    BYTE_WE  = 1'b1
  } bytectl_e;

  // Clocks in one beat of the fixed schedule
  function automatic int unsigned beat_clocks(
    input logic        first,
    input logic        wr,
    input int unsigned rd0,
    input int unsigned wr0,
    input int unsigned nxt
  );
    if (!first) return nxt;
    return wr ? wr0 : rd0;
  endfunction

endpackage

// File: rtl/l2_beat_seq.sv
module l2_beat_seq
  import l2_seq_pkg::*;
#(
  parameter int unsigned BEATS    = 4,
  parameter int unsigned FIRST_RD = 3,
  parameter int unsigned FIRST_WR = 4,
  parameter int unsigned NEXT_CLK = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     in_wr,
  input  logic                     in_multi,
  input  logic                     in_bmode,
  input  logic [$clog2(BEATS)-1:0] in_start,
  output logic                     active,
  output logic                     wr,
  output logic [$clog2(BEATS)-1:0] ca_lo,
  output logic                     strobe,
  output logic                     adv,
  output logic                     rdy
);
  localparam int unsigned BEAT_W  = $clog2(BEATS);
  localparam int unsigned MAX_LEN = (FIRST_WR > FIRST_RD) ?
                                    ((FIRST_WR > NEXT_CLK) ? FIRST_WR : NEXT_CLK) :
                                    ((FIRST_RD > NEXT_CLK) ? FIRST_RD : NEXT_CLK);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  logic              act_q, wr_q, multi_q, bmode_q;
  logic [BEAT_W-1:0] start_q, beat_q;
  logic [CNT_W-1:0]  cnt_q, len;
  logic              first_beat, last_clk, last_beat;

  // Interleaved order: start address XOR beat index
  function automatic logic [BEAT_W-1:0] interleave(
    input logic [BEAT_W-1:0] s,
    input logic [BEAT_W-1:0] b
  );
    return s ^ b;
  endfunction

  assign first_beat = (beat_q == '0);
  assign len        = CNT_W'(beat_clocks(first_beat, wr_q, FIRST_RD, FIRST_WR, NEXT_CLK));
  assign last_clk   = act_q && (cnt_q == len - 1'b1);
  assign last_beat  = !multi_q || (beat_q == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      multi_q <= 1'b0;
      bmode_q <= 1'b0;
      start_q <= '0;
      beat_q  <= '0;
      cnt_q   <= '0;
    end else if (accept) begin
      act_q   <= 1'b1;
      wr_q    <= in_wr;
      multi_q <= in_multi;
      bmode_q <= in_bmode;
      start_q <= in_start;
      beat_q  <= '0;
      cnt_q   <= '0;
    end else if (act_q) begin
      if (last_clk) begin
        cnt_q  <= '0;
        beat_q <= beat_q + 1'b1;
        if (last_beat) act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active = act_q;
  assign wr     = wr_q;
  assign ca_lo  = bmode_q ? start_q : interleave(start_q, beat_q);
  assign strobe = act_q && bmode_q && first_beat && (cnt_q == '0);
  assign adv    = act_q && bmode_q && !first_beat && (cnt_q == '0);
  assign rdy    = last_clk;

  // Plain SRAMs: a new beat always presents a new quadword
  assert_std_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !bmode_q && last_clk && !last_beat) |=> (ca_lo != $past(ca_lo)));

  // Burst SRAMs: address is frozen after the strobe cycle
  assert_burst_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && bmode_q && !strobe) |-> $stable(ca_lo));

  // A single access ends with its only ready pulse
  assert_single_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !multi_q) |=> !act_q);

endmodule

// File: rtl/l2_byte_ctl.sv
module l2_byte_ctl
  import l2_seq_pkg::*;
#(
  parameter int unsigned BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [BYTES-1:0] in_be,
  input  logic             in_mode,
  input  logic             active,
  input  logic             wr,
  output logic [BYTES-1:0] lanes,
  output logic [1:0]       rw
);
  logic [BYTES-1:0] be_q;
  bytectl_e         mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      be_q   <= '0;
      mode_q <= BYTE_SEL;
    end else if (accept) begin
      be_q   <= in_be;
      mode_q <= bytectl_e'(in_mode);
    end
  end

  always_comb begin
    lanes = '0;
    rw    = 2'b00;
    if (active) begin
      if (mode_q == BYTE_WE) begin
        lanes = wr ? be_q : '0;
      end else begin
        lanes = be_q;
        rw    = {2{wr}};
      end
    end
  end

  // Lanes cannot change in the middle of an access
  assert_lanes_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(lanes));

endmodule

// File: rtl/l2_wb_walk.sv
module l2_wb_walk #(
  parameter int unsigned LINES   = 4,
  parameter int unsigned WB_CLKS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [LINES-1:0]         dirty,
  output logic                     active,
  output logic [$clog2(LINES)-1:0] line,
  output logic                     done
);
  localparam int unsigned LINE_W = $clog2(LINES);
  localparam int unsigned CNT_W  = $clog2(WB_CLKS + 1);

  logic [LINES-1:0] pend_q, pend_rest;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q, done_q;

  // Lowest flagged line still pending
  function automatic logic [LINE_W-1:0] first_set(input logic [LINES-1:0] m);
    logic [LINE_W-1:0] r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (m[i]) r = LINE_W'(i);
    end
    return r;
  endfunction

  assign line      = first_set(pend_q);
  assign pend_rest = pend_q & ~(LINES'(1) << line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        pend_q <= dirty;
        cnt_q  <= '0;
        act_q  <= |dirty;
        done_q <= ~|dirty;
      end else if (act_q) begin
        if (cnt_q == CNT_W'(WB_CLKS - 1)) begin
          cnt_q  <= '0;
          pend_q <= pend_rest;
          if (pend_rest == '0) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign active = act_q;
  assign done   = done_q;

  // Lines are visited in ascending order within one walk
  assert_ascend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q)) |-> (line >= $past(line)));

endmodule

// File: rtl/l2_seq_top.sv
module l2_seq_top #(
  parameter int unsigned BEATS    = 4,
  parameter int unsigned LINES    = 4,
  parameter int unsigned BYTES    = 8,
  parameter int unsigned FIRST_RD = 3,
  parameter int unsigned FIRST_WR = 4,
  parameter int unsigned NEXT_CLK = 2,
  parameter int unsigned WB_CLKS  = 4,
  localparam int unsigned LO_W    = $clog2(BEATS),
  localparam int unsigned HI_W    = $clog2(LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_burst,
  input  logic [HI_W+LO_W-1:0] req_addr,
  input  logic [BYTES-1:0]     req_be,
  input  logic                 strap_burst_sram,
  input  logic                 byte_mode,
  input  logic                 wb_start,
  input  logic [LINES-1:0]     wb_dirty,
  output logic [LO_W-1:0]      ca_lo_a,
  output logic [LO_W-1:0]      ca_lo_b,
  output logic [HI_W-1:0]      ca_hi,
  output logic                 c_strobe,
  output logic                 c_adv,
  output logic                 c_oe,
  output logic [BYTES-1:0]     c_byte,
  output logic [1:0]           c_rw,
  output logic                 rdy,
  output logic                 busy,
  output logic                 wb_done
);
  logic            seq_act, seq_wr, wb_act;
  logic            accept, wb_go;
  logic [LO_W-1:0] seq_lo, lo_mux;
  logic [HI_W-1:0] wb_line, hi_q;

  // Request wins over a writeback raised in the same idle cycle
  assign busy   = seq_act || wb_act;
  assign accept = req_valid && !busy;
  assign wb_go  = wb_start && !busy && !req_valid;

  l2_beat_seq #(
    .BEATS(BEATS), .FIRST_RD(FIRST_RD), .FIRST_WR(FIRST_WR), .NEXT_CLK(NEXT_CLK)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .in_wr(req_write), .in_multi(req_burst), .in_bmode(strap_burst_sram),
    .in_start(req_addr[LO_W-1:0]),
    .active(seq_act), .wr(seq_wr), .ca_lo(seq_lo),
    .strobe(c_strobe), .adv(c_adv), .rdy(rdy)
  );

  l2_byte_ctl #(.BYTES(BYTES)) u_bytes (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .in_be(req_be), .in_mode(byte_mode),
    .active(seq_act), .wr(seq_wr),
    .lanes(c_byte), .rw(c_rw)
  );

  l2_wb_walk #(.LINES(LINES), .WB_CLKS(WB_CLKS)) u_wb (
    .clk(clk), .rst_n(rst_n), .start(wb_go), .dirty(wb_dirty),
    .active(wb_act), .line(wb_line), .done(wb_done)
  );

  // Line address is captured for the whole access
  always_ff @(posedge clk) begin
    if (!rst_n)      hi_q <= '0;
    else if (accept) hi_q <= req_addr[HI_W+LO_W-1:LO_W];
  end

  always_comb begin
    if (seq_act)     lo_mux = seq_lo;
    else if (wb_act) lo_mux = '0;
    else             lo_mux = req_addr[LO_W-1:0];
  end

  assign ca_lo_a = lo_mux;
  assign ca_lo_b = lo_mux;
  assign ca_hi   = wb_act ? wb_line : (seq_act ? hi_q : req_addr[HI_W+LO_W-1:LO_W]);
  assign c_oe    = (seq_act && !seq_wr) || wb_act;

  assert_hi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_act && $past(seq_act)) |-> $stable(ca_hi));

  // Output enable never coincides with a write on the read/write lines
  assert_oe_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    c_oe |-> (c_rw == 2'b00));

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_act && wb_act));

endmodule

// File: tb/test_l2_seq_top.sv
module test_l2_seq_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_write, req_burst;
  logic [3:0] req_addr;
  logic [7:0] req_be;
  logic       strap_burst_sram, byte_mode, wb_start;
  logic [3:0] wb_dirty;
  logic [1:0] ca_lo_a, ca_lo_b, ca_hi, c_rw;
  logic       c_strobe, c_adv, c_oe, rdy, busy, wb_done;
  logic [7:0] c_byte;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  l2_seq_top i_l2_seq_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_burst(req_burst), .req_addr(req_addr), .req_be(req_be),
    .strap_burst_sram(strap_burst_sram), .byte_mode(byte_mode),
    .wb_start(wb_start), .wb_dirty(wb_dirty),
    .ca_lo_a(ca_lo_a), .ca_lo_b(ca_lo_b), .ca_hi(ca_hi),
    .c_strobe(c_strobe), .c_adv(c_adv), .c_oe(c_oe), .c_byte(c_byte),
    .c_rw(c_rw), .rdy(rdy), .busy(busy), .wb_done(wb_done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // One access, checked clock by clock against the schedule
  task automatic run_access(input bit wr, input bit multi, input bit bstrap, input bit bmode,
                            input logic [3:0] addr, input logic [7:0] be,
                            input bit poke, input bit with_wb);
    int nb;
    @(negedge clk);
    strap_burst_sram = bstrap; byte_mode = bmode;
    req_valid = 1'b1; req_write = wr; req_burst = multi;
    req_addr = addr; req_be = be; wb_start = with_wb; wb_dirty = 4'hF;
    #1;
    check("R5 idle ca_hi flow", ca_hi, addr[3:2]);
    check("R3 idle ca_lo flow", ca_lo_a, addr[1:0]);
    nb = multi ? 4 : 1;
    for (int b = 0; b < nb; b++) begin
      int len;
      len = (b == 0) ? (wr ? 4 : 3) : 2;
      for (int c = 0; c < len; c++) begin
        logic [1:0] exp_lo;
        logic [7:0] exp_byte;
        logic [1:0] exp_rw;
        @(negedge clk);
        req_valid = 1'b0; wb_start = 1'b0; req_addr = ~addr; req_be = ~be;
        if (poke && b == 0 && c == 1) begin
          req_valid = 1'b1; wb_start = 1'b1; req_addr = addr ^ 4'h5;
        end
        #1;
        exp_lo   = bstrap ? addr[1:0] : (addr[1:0] ^ 2'(b));
        exp_byte = bmode ? (wr ? be : 8'h00) : be;
        exp_rw   = bmode ? 2'b00 : (wr ? 2'b11 : 2'b00);
        check("R11 busy during access", busy, 1);
        check(bstrap ? "R4 address held" : "R3 interleaved address", ca_lo_a, exp_lo);
        check("R2 copies equal", ca_lo_b, ca_lo_a);
        check("R5 ca_hi latched", ca_hi, addr[3:2]);
        check("R4 strobe", c_strobe, bstrap && b == 0 && c == 0);
        check("R4 advance", c_adv, bstrap && b != 0 && c == 0);
        check("R6 rdy on last clock", rdy, c == len - 1);
        check("R10 output enable", c_oe, !wr);
        check(bmode ? "R8 write enables" : "R9 byte selects", c_byte, exp_byte);
        check(bmode ? "R8 rw idle" : "R9 rw lines", c_rw, exp_rw);
        check("R11 no writeback done", wb_done, 0);
      end
    end
    @(negedge clk);
    req_addr = addr; req_be = be;
    #1;
    check("R6 access ended", busy, 0);
    check("R6 no extra rdy", rdy, 0);
    check("R9 lanes idle", c_byte, 0);
  endtask

  task automatic run_wb(input logic [3:0] mask);
    @(negedge clk);
    wb_start = 1'b1; wb_dirty = mask; req_valid = 1'b0;
    @(negedge clk);
    wb_start = 1'b0; wb_dirty = 4'h0;
    for (int l = 0; l < 4; l++) begin
      if (mask[l]) begin
        for (int c = 0; c < 4; c++) begin
          #1;
          check("R7 busy in line", busy, 1);
          check("R7 line select", ca_hi, l);
          check("R7 oe in line", c_oe, 1);
          check("R7 low address zero", ca_lo_a, 0);
          check("R2 copies equal wb", ca_lo_b, ca_lo_a);
          check("R7 done not early", wb_done, 0);
          @(negedge clk);
        end
      end
    end
    #1;
    check("R7 done pulse", wb_done, 1);
    check("R7 idle at done", busy, 0);
    @(negedge clk);
    #1;
    check("R7 done one cycle", wb_done, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_burst = 0; req_addr = 0;
    req_be = 0; strap_burst_sram = 0; byte_mode = 0; wb_start = 0; wb_dirty = 0;
    repeat (3) @(negedge clk);
    check("R1 strobe in reset", c_strobe, 0);
    check("R1 oe in reset", c_oe, 0);
    check("R1 byte in reset", c_byte, 0);
    check("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 adv after reset", c_adv, 0);
    check("R1 rw after reset", c_rw, 0);
    check("R1 rdy after reset", rdy, 0);
    check("R1 done after reset", wb_done, 0);
    check("R1 busy after reset", busy, 0);
  endtask

  task automatic t_plain_sram();
    for (int s = 0; s < 4; s++) run_access(0, 1, 0, 1, {2'(s), 2'(s)}, 8'hFF, 0, 0);
    run_access(1, 1, 0, 1, 4'b1001, 8'h3C, 0, 0);
    run_access(0, 0, 0, 1, 4'b0110, 8'hA5, 0, 0);
    run_access(1, 0, 0, 1, 4'b1111, 8'h81, 0, 0);
  endtask

  task automatic t_burst_sram();
    run_access(0, 1, 1, 1, 4'b0111, 8'hFF, 0, 0);
    run_access(1, 1, 1, 1, 4'b1010, 8'h0F, 0, 0);
    run_access(0, 0, 1, 1, 4'b0001, 8'hF0, 0, 0);
  endtask

  task automatic t_byte_select();
    run_access(1, 1, 0, 0, 4'b0110, 8'h5A, 0, 0);
    run_access(0, 1, 0, 0, 4'b1101, 8'hC3, 0, 0);
    run_access(1, 0, 1, 0, 4'b0010, 8'h18, 0, 0);
  endtask

  task automatic t_ignore();
    run_access(0, 1, 0, 1, 4'b1110, 8'hFF, 1, 0);   // R11 mid-access pokes
    run_access(1, 0, 1, 0, 4'b0101, 8'h77, 0, 1);   // R11 simultaneous start
  endtask

  task automatic t_writeback();
    run_wb(4'b0000);
    run_wb(4'b0100);
    run_wb(4'b1010);
    run_wb(4'b1111);
  endtask

  initial begin
    t_reset();
    t_plain_sram();
    t_burst_sram();
    t_byte_select();
    t_ignore();
    t_writeback();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule